// File: doc/BRIEF.md
# Mode-Selectable Utility Counter

A 16-bit counter sits beside a message controller and serves either as a free-running time stamp or as a software watchdog. Software sets it up through a small register port. A configuration word holds a run enable, a trigger enable, a self-clearing reload/clear strobe and a 4-bit mode field. A second word holds the reload value used in watchdog mode. In time stamp mode the counter counts up. In watchdog mode it counts down toward zero. When it reaches zero it raises a sticky expiry flag and stops.

Both the software strobe and a receive pulse from one fixed mailbox act as a restart event. In watchdog mode the event reloads the counter and clears the flag. In time stamp mode it clears the counter. The mailbox pulse counts only when the trigger enable is set and one of the two real modes is selected. The counter value and the expiry flag are registered outputs. The counter can also be read back through the register port.

Top module: `util_counter_top`

## Requirements
- R1: After a synchronous reset, the enable, trigger enable, mode, reload value, counter and expiry flag are all 0.
- R2: Register address 0 is the configuration word: bit 7 enable, bit 6 trigger enable, bit 5 strobe, bits 3:0 mode. Bit 4, bit 5 and bits 15:8 read as 0. Address 1 is the 16-bit reload value. Address 2 returns the counter and cannot be written. Address 3 reads 0. Read data is registered and appears one cycle after the read address is presented.
- R3: While the enable bit is 0 and no restart event occurs, the counter holds its value.
- R4: With mode 1 (time stamp) and enable 1, the counter increments by one each cycle and wraps from 0xFFFF to 0x0000.
- R5: With mode 2 (watchdog) and enable 1, the counter decrements each cycle. When a decrement reaches 0, or the counter is already 0, the expiry flag sets. While the flag is set the counter does not decrement. Only a watchdog-mode restart clears the flag.
- R6: Writing 1 to configuration bit 5 causes a restart one clock after the write. In mode 2 the restart loads the reload value and clears the flag. In any other mode it clears the counter to 0. This does not depend on the enable bit.
- R7: A mailbox receive pulse with the trigger enable set causes a restart at the same clock edge. In mode 2 it reloads the counter; in mode 1 it clears it.
- R8: A mailbox receive pulse has no effect when the trigger enable is 0, or when the mode is not 1 or 2.
- R9: Modes 0 and 3 to 15 perform no counting, even with enable set.
- R10: A strobe restart and a mailbox restart in the same cycle together perform exactly one restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write enable |
| reg_waddr | input | 2 | Write address |
| reg_wdata | input | 16 | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | 16 | Registered read data |
| mbx_rx_pulse | input | 1 | One-cycle receive pulse from the fixed mailbox |
| count_o | output | 16 | Counter value |
| expired_o | output | 1 | Sticky watchdog expiry flag |

## Verification
The bench steps the counter through several wraps, as follows:
- **Time stamp wrap:** it loads 0xFFFE in watchdog mode and then switches to time stamp mode, so it crosses 0xFFFF. A design that saturates there, or loses the carry, miscompares on the very next vector.
- **Watchdog expiry:** it runs the counter down to 0 and checks that the flag stays set and the counter stays stopped. It also tries a clear in time stamp mode. A design that lets that clear reset the flag is caught, and so is one that keeps decrementing past zero.
- **Reload of zero:** a reload value of 0 must set the flag on the next enabled cycle.
- **Restart timing:** the strobe must act one cycle after its write, while the mailbox pulse acts at its own edge. Both arrive together once, and the bench expects a single restart. An off-by-one in the strobe pipeline shows up as a one-count skew.
- **Ignored triggers:** the bench also targets pulses that must be ignored: with the trigger enable off, in reserved modes, and in modes 3 to 15.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;
  localparam int CFG_EN_BIT   = 7;
  localparam int CFG_TRIG_BIT = 6;
  localparam int CFG_SWC_BIT  = 5;
  localparam int CFG_MODE_W   = 4;

  localparam logic [CFG_MODE_W-1:0] MODE_TSTAMP = 4'd1;
  localparam logic [CFG_MODE_W-1:0] MODE_WDOG   = 4'd2;

  localparam int ADDR_CFG    = 0;
  localparam int ADDR_RELOAD = 1;
  localparam int ADDR_COUNT  = 2;

  typedef struct packed {
    logic                  run_en;
    logic                  trig_en;
    logic [CFG_MODE_W-1:0] mode;
  } ucnt_cfg_t;
endpackage

// File: rtl/ucnt_regs.sv
module ucnt_regs
  import ucnt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  input  logic [DATA_W-1:0] count,
  output ucnt_cfg_t         cfg,
  output logic [DATA_W-1:0] reload,
  output logic              swc_pulse,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(ADDR_CFG);
  localparam logic [ADDR_W-1:0] A_RLD = ADDR_W'(ADDR_RELOAD);
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(ADDR_COUNT);

  ucnt_cfg_t         cfg_q;
  logic [DATA_W-1:0] reload_q;
  logic              swc_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] cfg_view;
  logic              wr_cfg;
  logic              wr_rld;

  assign wr_cfg = we && (waddr == A_CFG);
  assign wr_rld = we && (waddr == A_RLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      reload_q <= '0;
      swc_q    <= 1'b0;
    end else begin
      swc_q <= wr_cfg && wdata[CFG_SWC_BIT];
      if (wr_cfg) begin
        cfg_q.run_en  <= wdata[CFG_EN_BIT];
        cfg_q.trig_en <= wdata[CFG_TRIG_BIT];
        cfg_q.mode    <= wdata[CFG_MODE_W-1:0];
      end
      if (wr_rld) reload_q <= wdata;
    end
  end

  always_comb begin
    cfg_view = '0;
    cfg_view[CFG_EN_BIT]       = cfg_q.run_en;
    cfg_view[CFG_TRIG_BIT]     = cfg_q.trig_en;
    cfg_view[CFG_MODE_W-1:0]   = cfg_q.mode;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      case (raddr)
        A_CFG:   rdata_q <= cfg_view;
        A_RLD:   rdata_q <= reload_q;
        A_CNT:   rdata_q <= count;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign cfg       = cfg_q;
  assign reload    = reload_q;
  assign swc_pulse = swc_q;
  assign rdata     = rdata_q;

  logic unused_wdata;
  assign unused_wdata = ^{wdata[DATA_W-1:CFG_EN_BIT+1], wdata[CFG_SWC_BIT-1:CFG_MODE_W]};

  // R2
  cfg_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (raddr == A_CFG) |=> (rdata[DATA_W-1:CFG_EN_BIT+1] == '0) && (rdata[CFG_SWC_BIT:CFG_MODE_W] == '0));
  // R6
  swc_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_cfg && wdata[CFG_SWC_BIT]) |=> swc_pulse);
  // R6
  swc_single_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_cfg && wdata[CFG_SWC_BIT]) |=> !swc_pulse);
endmodule

// File: rtl/ucnt_ctl.sv
module ucnt_ctl
  import ucnt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  ucnt_cfg_t cfg,
  input  logic      swc_pulse,
  input  logic      mbx_pulse,
  output logic      do_load,
  output logic      do_clear,
  output logic      do_inc,
  output logic      do_dec
);
  logic is_ts, is_wd, hw_evt, any_evt;

  assign is_ts   = (cfg.mode == MODE_TSTAMP);
  assign is_wd   = (cfg.mode == MODE_WDOG);
  assign hw_evt  = mbx_pulse && cfg.trig_en && (is_ts || is_wd);
  assign any_evt = swc_pulse || hw_evt;

  assign do_load  = any_evt && is_wd;
  assign do_clear = any_evt && !is_wd;
  assign do_inc   = cfg.run_en && is_ts && !any_evt;
  assign do_dec   = cfg.run_en && is_wd && !any_evt;

  // R10
  one_action_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({do_load, do_clear, do_inc, do_dec}));
  // R8
  trig_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!swc_pulse && (!cfg.trig_en || !(is_ts || is_wd))) |-> !(do_load || do_clear));
  // R9
  reserved_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(is_ts || is_wd) |-> !(do_inc || do_dec));
endmodule

// File: rtl/ucnt_core.sv
module ucnt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_load,
  input  logic             do_clear,
  input  logic             do_inc,
  input  logic             do_dec,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;
  logic             exp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (do_load) begin
      cnt_q <= reload;
      exp_q <= 1'b0;
    end else if (do_clear) begin
      cnt_q <= '0;
    end else if (do_inc) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (do_dec && !exp_q) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (cnt_q <= CNT_W'(1)) exp_q <= 1'b1;
    end
  end

  assign count   = cnt_q;
  assign expired = exp_q;

  // R5
  exp_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (expired && !do_load) |=> expired);
  // R5
  exp_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (expired && do_dec) |=> $stable(count));
  // R6
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    do_load |=> (count == $past(reload)) && !expired);
  // R4
  inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    do_inc |=> count == $past(count) + 1'b1);
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(do_load || do_clear || do_inc || do_dec) |=> $stable(count));
endmodule

// File: rtl/util_counter_top.sv
module util_counter_top
  import ucnt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_waddr,
  input  logic [CNT_W-1:0]  reg_wdata,
  input  logic [ADDR_W-1:0] reg_raddr,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              mbx_rx_pulse,
  output logic [CNT_W-1:0]  count_o,
  output logic              expired_o
);
  ucnt_cfg_t        cfg;
  logic [CNT_W-1:0] reload;
  logic             swc_pulse;
  logic             do_load, do_clear, do_inc, do_dec;

  ucnt_regs #(.DATA_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
    .raddr(reg_raddr), .count(count_o), .cfg(cfg), .reload(reload),
    .swc_pulse(swc_pulse), .rdata(reg_rdata)
  );

  ucnt_ctl u_ctl (
    .clk(clk), .rst(rst), .cfg(cfg), .swc_pulse(swc_pulse), .mbx_pulse(mbx_rx_pulse),
    .do_load(do_load), .do_clear(do_clear), .do_inc(do_inc), .do_dec(do_dec)
  );

  ucnt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .do_load(do_load), .do_clear(do_clear),
    .do_inc(do_inc), .do_dec(do_dec), .reload(reload),
    .count(count_o), .expired(expired_o)
  );
endmodule

// File: tb/sim_util_counter_top.sv
`timescale 1ns/1ps
module sim_util_counter_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_waddr = '0;
  logic [15:0] reg_wdata = '0;
  logic [1:0]  reg_raddr = '0;
  logic [15:0] reg_rdata;
  logic        mbx_rx_pulse = 1'b0;
  logic [15:0] count_o;
  logic        expired_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench-side expected state
  bit        m_en, m_trig, m_swc, m_exp;
  bit [3:0]  m_mode;
  bit [15:0] m_reload, m_cnt;

  always #4 clk = ~clk;

  util_counter_top u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .mbx_rx_pulse(mbx_rx_pulse),
    .count_o(count_o), .expired_o(expired_o)
  );

  function automatic bit [15:0] exp_read(input bit [1:0] a);
    case (a)
      2'd0: return {8'h00, m_en, m_trig, 2'b00, m_mode};
      2'd1: return m_reload;
      2'd2: return m_cnt;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic bit [15:0] cfg_word(input bit en, input bit trig, input bit swc, input bit [3:0] mode);
    return {8'hA5, en, trig, swc, 1'b1, mode};
  endfunction

  task automatic check(input string tag, input bit [15:0] act, input bit [15:0] expv, input string what);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic step(input bit we, input bit [1:0] wa, input bit [15:0] wd,
                      input bit [1:0] ra, input bit mbx, input string tag);
    bit [15:0] e_rd;
    bit is_ts, is_wd, evt;
    e_rd  = exp_read(ra);
    is_ts = (m_mode == 4'd1);
    is_wd = (m_mode == 4'd2);
    evt   = m_swc || (mbx && m_trig && (is_ts || is_wd));
    if (evt && is_wd) begin m_cnt = m_reload; m_exp = 1'b0; end
    else if (evt) m_cnt = '0;
    else if (m_en && is_ts) m_cnt = m_cnt + 16'd1;
    else if (m_en && is_wd && !m_exp) begin
      if (m_cnt <= 16'd1) m_exp = 1'b1;
      if (m_cnt != 16'd0) m_cnt = m_cnt - 16'd1;
    end
    m_swc = we && (wa == 2'd0) && wd[5];
    if (we && wa == 2'd0) begin m_en = wd[7]; m_trig = wd[6]; m_mode = wd[3:0]; end
    if (we && wa == 2'd1) m_reload = wd;
    reg_we = we; reg_waddr = wa; reg_wdata = wd; reg_raddr = ra; mbx_rx_pulse = mbx;
    @(posedge clk);
    @(negedge clk);
    check(tag, count_o, m_cnt, "count");
    check(tag, {15'd0, expired_o}, {15'd0, m_exp}, "expired");
    check(tag, reg_rdata, e_rd, "rdata");
  endtask

  task automatic idle(input int n, input bit [1:0] ra, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 16'h0, ra, 1'b0, tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    bit [15:0] wd;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", count_o, 16'h0, "count");
    check("R1", {15'd0, expired_o}, 16'h0, "expired");
    step(1'b0, 2'd0, 16'h0, 2'd0, 1'b0, "R1");
    step(1'b0, 2'd0, 16'h0, 2'd1, 1'b0, "R1");
    // R2: reserved bits read zero, reload readback, count not writable
    step(1'b1, 2'd0, 16'hFFF3, 2'd0, 1'b0, "R2");
    step(1'b1, 2'd2, 16'h1234, 2'd0, 1'b0, "R2");
    step(1'b1, 2'd1, 16'h0006, 2'd3, 1'b0, "R2");
    step(1'b0, 2'd0, 16'h0, 2'd1, 1'b0, "R2");
    // R9: reserved mode 3 with enable, no counting
    step(1'b1, 2'd0, cfg_word(1, 1, 0, 4'd3), 2'd2, 1'b0, "R9");
    idle(4, 2'd2, "R9");
    // R8: trigger in reserved mode ignored
    step(1'b0, 2'd0, 16'h0, 2'd2, 1'b1, "R8");
    // R6: strobe in watchdog mode with enable off loads reload value
    step(1'b1, 2'd0, cfg_word(0, 0, 1, 4'd2), 2'd2, 1'b0, "R6");
    idle(2, 2'd0, "R6");
    // R3: enable low holds
    idle(4, 2'd2, "R3");
    // R5: run down to zero and stay expired
    step(1'b1, 2'd0, cfg_word(1, 0, 0, 4'd2), 2'd2, 1'b0, "R5");
    idle(10, 2'd2, "R5");
    // R8: trigger with trig-en 0 ignored, flag stays
    step(1'b0, 2'd0, 16'h0, 2'd2, 1'b1, "R8");
    // R7: trigger with trig-en reloads in watchdog mode
    step(1'b1, 2'd0, cfg_word(1, 1, 0, 4'd2), 2'd2, 1'b0, "R7");
    step(1'b0, 2'd0, 16'h0, 2'd2, 1'b1, "R7");
    idle(2, 2'd2, "R7");
    // R5: reload value of zero expires on next enabled cycle
    step(1'b1, 2'd1, 16'h0000, 2'd1, 1'b0, "R5");
    step(1'b1, 2'd0, cfg_word(1, 0, 1, 4'd2), 2'd2, 1'b0, "R5");
    idle(3, 2'd2, "R5");
    // R4: wrap from FFFF
    step(1'b1, 2'd1, 16'hFFFE, 2'd1, 1'b0, "R4");
    step(1'b1, 2'd0, cfg_word(0, 0, 1, 4'd2), 2'd2, 1'b0, "R4");
    idle(1, 2'd2, "R4");
    step(1'b1, 2'd0, cfg_word(1, 1, 0, 4'd1), 2'd2, 1'b0, "R4");
    idle(4, 2'd2, "R4");
    // R7: trigger clears in time stamp mode
    step(1'b0, 2'd0, 16'h0, 2'd2, 1'b1, "R7");
    idle(3, 2'd2, "R7");
    // R10: strobe and trigger in the same cycle
    step(1'b1, 2'd0, cfg_word(1, 1, 1, 4'd1), 2'd2, 1'b0, "R10");
    step(1'b0, 2'd0, 16'h0, 2'd2, 1'b1, "R10");
    idle(3, 2'd2, "R10");
    // constrained random mix
    for (int i = 0; i < 6000; i++) begin
      bit we, mbx;
      bit [1:0] wa, ra;
      bit [3:0] md;
      we  = ($urandom % 8) == 0;
      wa  = ($urandom % 3 == 0) ? 2'd1 : 2'($urandom % 4 == 0 ? 2 : 0);
      ra  = 2'($urandom % 4);
      mbx = ($urandom % 10) == 0;
      md  = ($urandom % 6 == 0) ? 4'($urandom) : (($urandom % 2) ? 4'd1 : 4'd2);
      if (wa == 2'd1) wd = ($urandom % 2) ? 16'($urandom % 24) : 16'($urandom);
      else wd = {8'($urandom), 1'($urandom % 4 != 0), 1'($urandom), 1'($urandom % 5 == 0), 1'($urandom), md};
      step(we, wa, wd, ra, mbx, "R3/R4/R5/R6/R7/R8/R9/R10");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule